// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of an 8-bit successive-approximation converter that is shared by a multiplexed group of recording channels. It runs every conversion on a fixed 16-clock frame. The frame has three parts:

- A 7-clock acquisition phase, with the sample switch closed.
- Eight single-clock bit trials, working from the most significant bit down.
- One closing slot, in which the finished code is presented and flagged, and the input multiplexer is told to move to its next channel.

The capacitor array, the comparator and the input buffer are outside the block. The comparator is seen as one input bit, `cmp_below`, sampled at the end of each trial cycle.

While `enable` is high, frames follow each other with no gap. When `enable` drops, the frame in progress runs to its end and the sequencer then waits. It starts a new frame on the clock after it sees `enable` high again.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A frame is exactly 16 cycles long, numbered 0 to 15. While `enable` stays high, cycle 0 of the next frame directly follows cycle 15 of the current one.
- R2: `sample_en` is 1 in frame cycles 0 to 6 and 0 in every other cycle, including idle cycles.
- R3: Frame cycle 7+k is the trial for bit 7-k, for k = 0 to 7. During a trial, `dac_code` holds the bits already decided above the bit under test, a 1 in the bit under test, and 0 in every lower bit.
- R4: At the end of each trial cycle, the bit under test is cleared if `cmp_below` is 1 and kept if it is 0. `cmp_below` has no effect in acquisition and closing cycles. For an ideal comparator that reports input < `dac_code`, the result equals the input value.
- R5: In frame cycle 15, `result_valid` and `channel_next` are both 1 for that single cycle, and `result` carries the eight decided bits. `result` then holds this value until the next closing cycle.
- R6: `dac_code` is 0 during acquisition cycles and idle cycles. In the closing cycle it equals `result`.
- R7: If `enable` is 0 at the end of frame cycle 15, the block goes idle, and all outputs stay low except `result`. A frame begins on the cycle after `enable` is seen high while idle. Dropping `enable` before cycle 15 does not shorten the frame.
- R8: While `rst_n` is low, the block is idle at frame cycle 0 and `sample_en`, `dac_code`, `result`, `result_valid` and `channel_next` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run conversions while high |
| cmp_below | input | 1 | Comparator: 1 means the input is below the DAC level |
| sample_en | output | 1 | Sample switch closed |
| dac_code | output | 8 | Code driven onto the capacitor DAC |
| result | output | 8 | Last finished conversion |
| result_valid | output | 1 | One-cycle strobe in the closing cycle |
| channel_next | output | 1 | One-cycle pulse telling the multiplexer to advance |

## Verification
A wrong frame count shows up at the ports within one frame, as a misplaced `sample_en` edge or a closing strobe that is not 16 cycles after the previous one. A wrong trial register shows up in the very next cycle, through `dac_code`: the next trial shows a wrong prefix, a stray low bit or a wrong test position. Because of this, every cycle's `dac_code` is compared against a code built from the comparator answers the bench itself supplied. An error in result capture or in the stop and restart logic shows up in the closing cycle, or in the first idle cycle after it.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // Frame phases, decoded from the frame counter.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2,
    PH_CLOSE  = 2'd3
  } sar_phase_e;

  localparam int DEF_RES_BITS      = 8;
  localparam int DEF_SAMPLE_CYCLES = 7;

endpackage

// File: rtl/sar_frame_timer.sv
module sar_frame_timer
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS      = DEF_RES_BITS,
  parameter int SAMPLE_CYCLES = DEF_SAMPLE_CYCLES,
  parameter int IDX_W         = $clog2(RES_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  output sar_phase_e       phase,
  output logic [IDX_W-1:0] bit_idx,
  output logic             last_trial
);

  localparam int FRAME_CYCLES = SAMPLE_CYCLES + RES_BITS + 1;
  localparam int CNT_W        = $clog2(FRAME_CYCLES);
  localparam logic [CNT_W-1:0] SAMPLE_C    = CNT_W'(SAMPLE_CYCLES);
  localparam logic [CNT_W-1:0] CLOSE_C     = CNT_W'(SAMPLE_CYCLES + RES_BITS);
  localparam logic [CNT_W-1:0] TRIAL_END_C = CNT_W'(SAMPLE_CYCLES + RES_BITS - 1);
  localparam logic [IDX_W-1:0] TOP_IDX     = IDX_W'(RES_BITS - 1);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             adv;
  logic [CNT_W-1:0] trial_off;

  // Next-state logic
  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (active_q) begin
      if (cnt_q == CLOSE_C) begin
        cnt_d    = '0;
        active_d = enable;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d    = '0;
      active_d = enable;
    end
  end

  assign adv = active_q | enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (adv) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  // Phase decode
  always_comb begin
    if (!active_q)              phase = PH_IDLE;
    else if (cnt_q < SAMPLE_C)  phase = PH_SAMPLE;
    else if (cnt_q < CLOSE_C)   phase = PH_TRIAL;
    else                        phase = PH_CLOSE;
  end

  assign trial_off  = cnt_q - SAMPLE_C;
  assign bit_idx    = (phase == PH_TRIAL) ? (TOP_IDX - trial_off[IDX_W-1:0]) : '0;
  assign last_trial = (phase == PH_TRIAL) && (cnt_q == TRIAL_END_C);

  // R1: counter steps by one inside a frame
  p_frame_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && (cnt_q != CLOSE_C) |=> active_q && (cnt_q == $past(cnt_q) + 1'b1));

  // R1: back-to-back frames while enabled
  p_frame_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CLOSE) && enable |=> (phase == PH_SAMPLE) && (cnt_q == '0));

  // R7: stop after the closing cycle when disabled
  p_frame_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CLOSE) && !enable |=> (phase == PH_IDLE));

  // R7: idle block starts a frame at cycle 0
  p_frame_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) && enable |=> (phase == PH_SAMPLE) && (cnt_q == '0));

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = DEF_RES_BITS,
  parameter int IDX_W    = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  sar_phase_e          phase,
  input  logic [IDX_W-1:0]    bit_idx,
  input  logic                cmp_below,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] code_next
);

  localparam logic [RES_BITS-1:0] ONE = RES_BITS'(1);

  logic [RES_BITS-1:0] kept_q, kept_d;
  logic [RES_BITS-1:0] test_bit;
  logic                upd;

  assign test_bit = ONE << bit_idx;

  // Next-state: clear on acquisition, decide one bit per trial
  always_comb begin
    kept_d = kept_q;
    unique case (phase)
      PH_SAMPLE: kept_d = '0;
      PH_TRIAL:  if (!cmp_below) kept_d = kept_q | test_bit;
      default:   kept_d = kept_q;
    endcase
  end

  assign upd       = (phase == PH_SAMPLE) || (phase == PH_TRIAL);
  assign code_next = kept_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kept_q <= '0;
    end else if (upd) begin
      kept_q <= kept_d;
    end
  end

  always_comb begin
    unique case (phase)
      PH_TRIAL: dac_code = kept_q | test_bit;
      PH_CLOSE: dac_code = kept_q;
      default:  dac_code = '0;
    endcase
  end

  // R3: bits below the one under test are zero during a trial
  p_low_bits_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TRIAL) |-> ((dac_code & (test_bit - ONE)) == '0));

  // R4: a "below" answer clears the tested bit
  p_clear_on_below_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TRIAL) && cmp_below |=> ((kept_q & $past(test_bit)) == '0));

  // R4: a "not below" answer keeps the tested bit
  p_keep_on_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TRIAL) && !cmp_below |=> ((kept_q & $past(test_bit)) != '0));

endmodule

// File: rtl/sar_result_stage.sv
module sar_result_stage
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = DEF_RES_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  sar_phase_e          phase,
  input  logic                last_trial,
  input  logic [RES_BITS-1:0] code_next,
  output logic [RES_BITS-1:0] result,
  output logic                result_valid,
  output logic                channel_next
);

  logic [RES_BITS-1:0] result_q, result_d;

  assign result_d = last_trial ? code_next : result_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (last_trial) begin
      result_q <= result_d;
    end
  end

  assign result       = result_q;
  assign result_valid = (phase == PH_CLOSE);
  assign channel_next = (phase == PH_CLOSE);

  // R5: strobe lasts one cycle
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R5: result only changes as the last trial ends
  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !last_trial |=> $stable(result_q));

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS      = DEF_RES_BITS,
  parameter int SAMPLE_CYCLES = DEF_SAMPLE_CYCLES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                cmp_below,
  output logic                sample_en,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] result,
  output logic                result_valid,
  output logic                channel_next
);

  localparam int IDX_W = $clog2(RES_BITS);

  sar_phase_e          phase;
  logic [IDX_W-1:0]    bit_idx;
  logic                last_trial;
  logic [RES_BITS-1:0] code_next;

  sar_frame_timer #(
    .RES_BITS      (RES_BITS),
    .SAMPLE_CYCLES (SAMPLE_CYCLES),
    .IDX_W         (IDX_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .phase      (phase),
    .bit_idx    (bit_idx),
    .last_trial (last_trial)
  );

  sar_bit_engine #(
    .RES_BITS (RES_BITS),
    .IDX_W    (IDX_W)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .bit_idx   (bit_idx),
    .cmp_below (cmp_below),
    .dac_code  (dac_code),
    .code_next (code_next)
  );

  sar_result_stage #(
    .RES_BITS (RES_BITS)
  ) u_result (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase        (phase),
    .last_trial   (last_trial),
    .code_next    (code_next),
    .result       (result),
    .result_valid (result_valid),
    .channel_next (channel_next)
  );

  assign sample_en = (phase == PH_SAMPLE);

  // R6: DAC parked at zero while sampling
  p_sample_dac_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (dac_code == '0));

  // R6: closing cycle presents the result on the DAC
  p_close_dac_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (dac_code == result));

  // R2: acquisition is followed by the first trial, with the MSB under test
  p_sample_to_trial_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_en) |-> dac_code[RES_BITS-1] && !result_valid);

  // R5: multiplexer advance coincides with the result strobe
  p_chan_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    channel_next |-> result_valid && !sample_en);

endmodule

// File: tb/sar_seq_ctrl_bench.sv
module sar_seq_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic       cmp_below;
  logic       sample_en;
  logic [7:0] dac_code;
  logic [7:0] result;
  logic       result_valid;
  logic       channel_next;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Comparator model: 0 ideal (input < dac), 1 random, 2 always below, 3 never below
  int mode  = 0;
  int vin   = 0;
  bit rnd_b = 1'b0;

  always #2 clk = ~clk;

  always_comb begin
    case (mode)
      0:       cmp_below = (vin < int'(dac_code));
      1:       cmp_below = rnd_b;
      2:       cmp_below = 1'b1;
      default: cmp_below = 1'b0;
    endcase
  end

  sar_seq_ctrl u_sar_seq_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .cmp_below    (cmp_below),
    .sample_en    (sample_en),
    .dac_code     (dac_code),
    .result       (result),
    .result_valid (result_valid),
    .channel_next (channel_next)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Answer the comparator would give for a trial with the given code.
  function automatic bit answer(input int m, input int v, input int code, input bit r);
    case (m)
      0:       return v < code;
      1:       return r;
      2:       return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Expected result of a full conversion with the ideal comparator.
  function automatic int ideal_code(input int v);
    int c = 0;
    for (int b = 7; b >= 0; b--) begin
      if (!(v < (c | (1 << b)))) c = c | (1 << b);
    end
    return c;
  endfunction

  // Checks one frame; the next negedge must be frame cycle 0.
  task automatic do_frame(input int m, input int v, input int drop_at, input int raise_at);
    int kept = 0;
    int expd;
    bit d;
    mode = m;
    vin  = v;
    for (int j = 0; j < 16; j++) begin
      @(negedge clk);
      if (j < 7) begin
        chk(sample_en == 1'b1, "R2 sample high", sample_en, 1);
        chk(dac_code == 8'd0, "R6 dac zero in sample", dac_code, 0);
        chk(result_valid == 1'b0, "R5 no strobe in sample", result_valid, 0);
      end else if (j < 15) begin
        int b = 14 - j;
        expd = kept | (1 << b);
        chk(sample_en == 1'b0, "R2 sample low in trial", sample_en, 0);
        chk(int'(dac_code) == expd, "R3 trial code", dac_code, expd);
        chk(channel_next == 1'b0, "R5 no advance in trial", channel_next, 0);
        rnd_b = 1'($urandom);
        d = answer(m, v, expd, rnd_b);
        if (!d) kept = expd;
      end else begin
        chk(result_valid == 1'b1, "R5 strobe in closing cycle", result_valid, 1);
        chk(channel_next == 1'b1, "R5 advance in closing cycle", channel_next, 1);
        chk(int'(result) == kept, "R4 result bits", result, kept);
        chk(int'(dac_code) == kept, "R6 dac equals result", dac_code, kept);
        chk(sample_en == 1'b0, "R2 sample low in close", sample_en, 0);
        if (m == 0) chk(int'(result) == ideal_code(v) && ideal_code(v) == v,
                        "R4 ideal conversion", result, v);
      end
      if (j < 7 || j == 15) rnd_b = 1'($urandom);
      if (j == drop_at)  enable = 1'b0;
      if (j == raise_at) enable = 1'b1;
    end
  endtask

  task automatic idle_check(input int n, input int held);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(sample_en == 1'b0, "R7 idle sample low", sample_en, 0);
      chk(dac_code == 8'd0, "R7 idle dac zero", dac_code, 0);
      chk(result_valid == 1'b0 && channel_next == 1'b0, "R7 idle no strobe",
          result_valid, 0);
      chk(int'(result) == held, "R5 result held while idle", result, held);
    end
  endtask

  initial begin
    void'($urandom(32'h5A17));
    rst_n  = 1'b0;
    enable = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(sample_en == 1'b0 && dac_code == 8'd0 && result == 8'd0 &&
        result_valid == 1'b0 && channel_next == 1'b0, "R8 reset outputs", 0, 0);
    rst_n = 1'b1;
    idle_check(3, 0);
    enable = 1'b1;

    // Directed corners, back to back (R1)
    do_frame(0, 0,   -1, -1);
    do_frame(0, 255, -1, -1);
    do_frame(0, 128, -1, -1);
    do_frame(0, 127, -1, -1);
    do_frame(0, 1,   -1, -1);
    do_frame(2, 0,   -1, -1);
    do_frame(3, 0,   -1, -1);

    // Random inputs, ideal comparator
    for (int k = 0; k < 20; k++) do_frame(0, int'($urandom % 256), -1, -1);
    // Random comparator answers (R4)
    for (int k = 0; k < 8; k++) do_frame(1, 0, -1, -1);

    // R7: brief enable dip inside a frame does not stop conversion
    do_frame(0, 77, 3, 10);
    do_frame(0, 200, -1, -1);

    // R7: drop enable mid-frame; frame completes, then idle
    do_frame(0, 99, 5, -1);
    idle_check(4, 99);
    enable = 1'b1;
    do_frame(0, 42, -1, -1);
    do_frame(0, 13, 15, -1);
    idle_check(2, 13);
    enable = 1'b1;

    // R8: reset mid-frame
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(sample_en == 1'b0 && dac_code == 8'd0 && result == 8'd0 &&
        result_valid == 1'b0, "R8 reset mid-frame", result, 0);
    rst_n = 1'b1;
    do_frame(0, 180, -1, -1);
    do_frame(0, 64, 15, -1);
    idle_check(2, 64);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule